// File: doc/BRIEF.md
# Two-Cycle Memory Occupancy Interlock

This block tracks a six-stage in-order pipeline: fetch, decode, execute, two memory stages (M0 then M1) and writeback. The data memory sits across M0 and M1, split by a pipeline register, but it is not pipelined internally. Only one load or store may be inside it at a time. The block carries each instruction's valid bit, memory-operation flag and tag down the stages. It raises a stall when a younger memory operation in execute would enter M0 while an older one is still in M0.

During a stall, fetch, decode and execute keep their contents and no new instruction is accepted. M0 receives a bubble while the older memory operation moves on into M1 and then writeback. The older instruction is never held. A non-memory instruction may follow a load into M0 and M1 with no delay. The memory array and operand forwarding are outside this block.

Top module: `memOccupancyInterlock`

## Requirements
- R1: After reset every stage is empty: `wbValid`, `stall`, `m0Busy` and `m1Busy` are low, and `fetchReady` is high.
- R2: An instruction accepted at a clock edge (`inValid` high and `fetchReady` high) appears on `wbValid`, `wbIsMem` and `wbTag` five edges later, delayed by one edge for each stall cycle it spends in fetch, decode or execute.
- R3: `stall` is high exactly when execute holds a valid memory operation and M0 holds a valid memory operation (`inIsMem` = 1 marks a load or store).
- R4: While `stall` is high, `fetchReady` is low, no input is accepted, and the fetch, decode and execute contents are unchanged at the next edge.
- R5: During a stall, M0 receives a bubble (not valid, memory flag clear) at the next edge, and the older operation in M0 moves into M1 without being held.
- R6: `m0Busy` and `m1Busy` are never high in the same cycle.
- R7: Two memory operations accepted on consecutive edges (load then load, or load then store) cost exactly one stall cycle. A non-memory instruction directly behind a load costs none, and neither does a load, a non-memory instruction, then a load.
- R8: Instructions leave writeback in the order they were accepted, with their tag and memory flag unchanged.
- R9: Three memory operations accepted on consecutive edges cost two stall cycles, and the third reaches writeback two edges later than it would without stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction offered to fetch |
| inIsMem | input | 1 | Offered instruction is a load or store |
| inTag | input | TAG_W | Identifier carried with the instruction |
| fetchReady | output | 1 | Fetch accepts the offered instruction at the next edge |
| stall | output | 1 | Front stages held and bubble injected into M0 |
| m0Busy | output | 1 | M0 holds a memory operation |
| m1Busy | output | 1 | M1 holds a memory operation |
| wbValid | output | 1 | Writeback stage holds an instruction |
| wbIsMem | output | 1 | Writeback instruction is a memory operation |
| wbTag | output | TAG_W | Writeback instruction's identifier |

## Verification
The bench feeds short sequences and compares the number of stall cycles and the writeback cycle of every instruction against values worked out by hand. Add-load-add and load-idle-load must show no stall, which separates the real occupancy condition from a rule that stalls on any nearby load. Load-load-add and load-store must show one stall, and the add's later arrival shows that the younger instructions behind it are held too. Load-add-load must show none, which shows that a memory operation in M1 does not block entry. Load-load-load must show two stalls, which shows that the bubble frees M0 for only one waiting operation at a time.

// File: rtl/memIlkPkg.sv
package memIlkPkg;
  // Stage positions; the interlock depends on X feeding M0 directly.
  localparam int STG_F   = 0;
  localparam int STG_D   = 1;
  localparam int STG_X   = 2;
  localparam int STG_M0  = 3;
  localparam int STG_M1  = 4;
  localparam int STG_W   = 5;
  localparam int NUM_STG = 6;

  // Strobes from the hazard control to the stage datapath.
  typedef struct packed {
    logic holdFront;  // freeze F, D and X
    logic bubbleM0;   // load an empty slot into M0
  } ilkStrobes_t;
endpackage

// File: rtl/memIlkCtrl.sv
module memIlkCtrl
  import memIlkPkg::*;
(
  input  logic        xMemValid,
  input  logic        m0MemValid,
  output ilkStrobes_t strobes
);
  logic conflict;

  // The M0 occupant moves to M1 next edge, so the memory stays taken:
  // the execute-stage memory op must wait one more cycle.
  always_comb begin
    conflict          = xMemValid && m0MemValid;
    strobes.holdFront = conflict;
    strobes.bubbleM0  = conflict;
  end
endmodule

// File: rtl/memIlkStages.sv
module memIlkStages
  import memIlkPkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inIsMem,
  input  logic [TAG_W-1:0] inTag,
  input  ilkStrobes_t      strobes,
  output logic             xMemValid,
  output logic             m0MemValid,
  output logic             m1MemValid,
  output logic [TAG_W-1:0] xTag,
  output logic             wbValid,
  output logic             wbIsMem,
  output logic [TAG_W-1:0] wbTag
);
  localparam int LAST_FRONT = STG_X;

  logic             curValid [NUM_STG];
  logic             curMem   [NUM_STG];
  logic [TAG_W-1:0] curTag   [NUM_STG];
  logic             nxtValid [NUM_STG];
  logic             nxtMem   [NUM_STG];
  logic [TAG_W-1:0] nxtTag   [NUM_STG];
  logic             stageEn  [NUM_STG];

  always_comb begin
    nxtValid[STG_F] = inValid;
    nxtMem[STG_F]   = inValid && inIsMem;
    nxtTag[STG_F]   = inTag;
    for (int s = 1; s < NUM_STG; s++) begin
      nxtValid[s] = curValid[s-1];
      nxtMem[s]   = curMem[s-1];
      nxtTag[s]   = curTag[s-1];
    end
    if (strobes.bubbleM0) begin
      nxtValid[STG_M0] = 1'b0;
      nxtMem[STG_M0]   = 1'b0;
      nxtTag[STG_M0]   = '0;
    end
    for (int s = 0; s < NUM_STG; s++) begin
      stageEn[s] = !(strobes.holdFront && (s <= LAST_FRONT));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_STG; s++) begin
        curValid[s] <= 1'b0;
        curMem[s]   <= 1'b0;
        curTag[s]   <= '0;
      end
    end else begin
      for (int s = 0; s < NUM_STG; s++) begin
        if (stageEn[s]) begin
          curValid[s] <= nxtValid[s];
          curMem[s]   <= nxtMem[s];
          curTag[s]   <= nxtTag[s];
        end
      end
    end
  end

  always_comb begin
    xMemValid  = curValid[STG_X]  && curMem[STG_X];
    m0MemValid = curValid[STG_M0] && curMem[STG_M0];
    m1MemValid = curValid[STG_M1] && curMem[STG_M1];
    xTag       = curTag[STG_X];
    wbValid    = curValid[STG_W];
    wbIsMem    = curMem[STG_W];
    wbTag      = curTag[STG_W];
  end
endmodule

// File: rtl/memOccupancyInterlock.sv
module memOccupancyInterlock
  import memIlkPkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inIsMem,
  input  logic [TAG_W-1:0] inTag,
  output logic             fetchReady,
  output logic             stall,
  output logic             m0Busy,
  output logic             m1Busy,
  output logic             wbValid,
  output logic             wbIsMem,
  output logic [TAG_W-1:0] wbTag
);
  ilkStrobes_t      strobes;
  logic             xMemValid;
  logic             m0MemValid;
  logic             m1MemValid;
  logic [TAG_W-1:0] xTag;

  memIlkCtrl i_ctrl (
    .xMemValid (xMemValid),
    .m0MemValid(m0MemValid),
    .strobes   (strobes)
  );

  memIlkStages #(.TAG_W(TAG_W)) i_stages (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inIsMem   (inIsMem),
    .inTag     (inTag),
    .strobes   (strobes),
    .xMemValid (xMemValid),
    .m0MemValid(m0MemValid),
    .m1MemValid(m1MemValid),
    .xTag      (xTag),
    .wbValid   (wbValid),
    .wbIsMem   (wbIsMem),
    .wbTag     (wbTag)
  );

  assign fetchReady = !strobes.holdFront;
  assign stall      = strobes.holdFront;
  assign m0Busy     = m0MemValid;
  assign m1Busy     = m1MemValid;
endmodule

// File: rtl/memOccupancyChecker.sv
module memOccupancyChecker #(
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             stall,
  input logic             fetchReady,
  input logic             xMemValid,
  input logic             m0Busy,
  input logic             m1Busy,
  input logic [TAG_W-1:0] xTag
);
  AST_STALL_REASON: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (xMemValid && m0Busy)); // R3
  AST_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !fetchReady); // R4
  AST_X_HELD: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (xMemValid && $stable(xTag))); // R4
  AST_M0_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !m0Busy); // R5
  AST_OLDER_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    m0Busy |=> m1Busy); // R5
  AST_SINGLE_OCCUPANT: assert property (@(posedge clk) disable iff (!rstN)
    !(m0Busy && m1Busy)); // R6
  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall); // R7
endmodule

bind memOccupancyInterlock memOccupancyChecker #(.TAG_W(TAG_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .stall     (stall),
  .fetchReady(fetchReady),
  .xMemValid (xMemValid),
  .m0Busy    (m0Busy),
  .m1Busy    (m1Busy),
  .xTag      (xTag)
);

// File: tb/test_memOccupancyInterlock.sv
module test_memOccupancyInterlock;
  localparam int TAG_W = 8;
  localparam int BASE_LAT = 6;  // edges counted from the drive cycle to W

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic             inIsMem = 1'b0;
  logic [TAG_W-1:0] inTag = '0;
  logic             fetchReady, stall, m0Busy, m1Busy, wbValid, wbIsMem;
  logic [TAG_W-1:0] wbTag;

  int checks = 0;
  int errors = 0;
  int cycle = 0;
  int stallCount = 0;
  int bothBusy = 0;
  bit finished = 0;

  int qTag[$];
  int qMem[$];
  int qCyc[$];

  memOccupancyInterlock #(.TAG_W(TAG_W)) i_memOccupancyInterlock (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIsMem(inIsMem),
    .inTag(inTag), .fetchReady(fetchReady), .stall(stall),
    .m0Busy(m0Busy), .m1Busy(m1Busy), .wbValid(wbValid),
    .wbIsMem(wbIsMem), .wbTag(wbTag)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  // Monitor: pops expected items as writeback produces them.
  always @(negedge clk) begin
    if (rstN) begin
      if (stall) stallCount++;
      if (m0Busy && m1Busy) bothBusy++;
      if (wbValid) begin
        checks++;
        if (qTag.size() == 0) begin
          errors++;
          $display("FAIL R8 unexpected writeback tag %0d, expected none", wbTag);
        end else begin
          int eT, eM, eC;
          eT = qTag.pop_front(); eM = qMem.pop_front(); eC = qCyc.pop_front();
          if (wbTag != eT || wbIsMem != eM[0]) begin
            errors++;
            $display("FAIL R8 writeback tag/mem %0d/%0d, expected %0d/%0d",
                     wbTag, wbIsMem, eT, eM);
          end else if (cycle != eC) begin
            errors++;
            $display("FAIL R2 tag %0d reached writeback at cycle %0d, expected %0d",
                     eT, cycle, eC);
          end
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: offers one instruction and records its expected writeback.
  // extra = stall cycles the instruction spends in F/D/X after acceptance.
  task automatic send(input bit mem, input int tag, input int extra);
    @(negedge clk);
    inValid = 1'b1; inIsMem = mem; inTag = tag[TAG_W-1:0];
    while (stall) @(negedge clk);
    qTag.push_back(tag); qMem.push_back(int'(mem));
    qCyc.push_back(cycle + BASE_LAT + extra);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    inValid = 1'b0; inIsMem = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finishSeq(input string req, input int expStalls);
    idle(12);
    check(req, stallCount, expStalls);
    check("R8", qTag.size(), 0);
    stallCount = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 wbValid", int'(wbValid), 0);
    check("R1 stall", int'(stall), 0);
    check("R1 fetchReady", int'(fetchReady), 1);
    check("R1 busy", int'(m0Busy) + int'(m1Busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    stallCount = 0;

    // R7: add, load, add -> no stall
    send(0, 1, 0); send(1, 2, 0); send(0, 3, 0);
    finishSeq("R7 add-load-add stalls", 0);

    // R7 R4 R5: load, load, add -> one stall, add behind held too
    send(1, 10, 0); send(1, 11, 1); send(0, 12, 1);
    finishSeq("R7 load-load-add stalls", 1);

    // R7: load then store
    send(1, 20, 0); send(1, 21, 1);
    finishSeq("R7 load-store stalls", 1);

    // R7: load, add, load -> M1 occupant does not block
    send(1, 30, 0); send(0, 31, 0); send(1, 32, 0);
    finishSeq("R7 load-add-load stalls", 0);

    // R3: load, gap, load -> no conflict
    send(1, 40, 0); idle(0); send(1, 41, 0);
    finishSeq("R3 load-idle-load stalls", 0);

    // R9: three memory operations back to back
    send(1, 50, 0); send(1, 51, 1); send(1, 52, 2);
    finishSeq("R9 load-load-load stalls", 2);

    // R6: one occupant at a time across all sequences
    check("R6 cycles with both memory stages busy", bothBusy, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired, actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule